// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 64-bit integers over a fixed run of clock cycles, retiring one multiplier bit per cycle through a single adder. A 128-bit product register carries the work. Its upper half collects the partial sums. Its lower half starts out holding the multiplier, which drains away as the product bits shift in behind it. Signs never enter the loop. Operands are reduced to magnitudes before the run, the unsigned magnitude product is formed, and the full 128-bit value is negated afterwards when the operand signs disagree.

A caller raises `start` for one cycle with both operands and a function code while `busy` is low. `busy` then stays high for the whole run. `done` pulses once when the result is ready. `start` is a plain control pin with no back-pressure: a request made while `busy` is high is dropped, not queued. The caller must wait for `busy` to fall before issuing the next request. `result` holds its value until the next accepted request, so the caller may read it at any time after the `done` pulse.

Top module: `seq_mul`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` and `done` are low.
- R2: `start` high on a clock edge where `busy` is low is accepted. `busy` reads high from that edge onward.
- R3: Counting the accepting edge as edge 0, `busy` stays high and `done` stays low through edge 63. On edge 64, `busy` falls and `done` rises.
- R4: `done` is high for exactly one cycle per accepted request.
- R5: `start` while `busy` is high has no effect. The result and the completion timing of the run in progress are unchanged.
- R6: Function code 2'b00 returns bits 63:0 of the product.
- R7: Function code 2'b01 returns bits 127:64 of the product, with both operands taken as two's-complement signed values.
- R8: Function code 2'b10 returns bits 127:64 of the product, with both operands taken as unsigned values.
- R9: Function code 2'b11 behaves exactly like 2'b00.
- R10: After `done`, `result` stays stable until the next accepted `start`.
- R11: Extreme operands give exact results for every function code: the most negative value, all-ones, zero and one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication when idle |
| func | input | 2 | 00 low, 01 signed high, 10 unsigned high, 11 low |
| op_a | input | 64 | Multiplicand |
| op_b | input | 64 | Multiplier |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Selected 64 bits of the product |

## Verification
A result is due on the 64th rising edge after the edge that accepts `start`. `busy` must read high from the accepting edge through edge 63 and low from edge 64. The bench drives inputs on falling edges and samples one nanosecond after each rising edge. It counts exactly 63 edges after acceptance to confirm the run is still busy, then one more to compare `done` and `result` against the language's own signed or unsigned 128-bit product. It samples one further edge to confirm that `done` has dropped and `result` has held. In some runs the bench fires stray `start` pulses mid-run with different operands, and the same counted schedule shows that these pulses neither alter the answer nor shift its arrival.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic [1:0] {
    FN_LOW  = 2'b00,
    FN_SHI  = 2'b01,
    FN_UHI  = 2'b10,
    FN_LOW2 = 2'b11
  } mul_fn_e;
endpackage

// File: rtl/seq_mul_sign.sv
module seq_mul_sign #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         signed_op,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         negate
);
  logic neg_a, neg_b;

  always_comb begin
    neg_a  = signed_op & a[W-1];
    neg_b  = signed_op & b[W-1];
    mag_a  = neg_a ? (~a + 1'b1) : a;
    mag_b  = neg_b ? (~b + 1'b1) : b;
    negate = neg_a ^ neg_b;
  end
endmodule

// File: rtl/seq_mul_core.sv
module seq_mul_core #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic           running,
  output logic           finish,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  mcand;
  logic [CW-1:0] step;
  logic [W:0]    sum;

  always_comb begin
    sum = {1'b0, prod[2*W-1:W]} + {1'b0, (prod[0] ? mcand : {W{1'b0}})};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod    <= '0;
      mcand   <= '0;
      step    <= '0;
      running <= 1'b0;
      finish  <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (load && !running) begin
        prod    <= {{W{1'b0}}, mplier_in};
        mcand   <= mcand_in;
        step    <= '0;
        running <= 1'b1;
      end else if (running) begin
        prod <= {sum, prod[W-1:1]};
        step <= step + 1'b1;
        if (step == LAST) begin
          running <= 1'b0;
          finish  <= 1'b1;
        end
      end
    end
  end

  // R5: the multiplicand is frozen for the whole run
  p_mcand_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |-> $stable(mcand));
  // R3: the run ends by raising finish and dropping running together
  p_finish_ends_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> finish);
  // R4: finish never lasts two cycles
  p_finish_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !finish);
endmodule

// File: rtl/seq_mul_select.sv
module seq_mul_select
  import seq_mul_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [2*W-1:0] prod,
  input  logic           negate,
  input  mul_fn_e        fn,
  output logic [W-1:0]   result
);
  logic [2*W-1:0] fixed;

  always_comb begin
    fixed = negate ? (~prod + 1'b1) : prod;
    unique case (fn)
      FN_SHI, FN_UHI: result = fixed[2*W-1:W];
      default:        result = fixed[W-1:0];
    endcase
  end
endmodule

// File: rtl/seq_mul.sv
module seq_mul
  import seq_mul_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   func,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  logic [W-1:0]   mag_a, mag_b;
  logic           neg_now, neg_q;
  mul_fn_e        fn_q;
  logic [2*W-1:0] prod;
  logic           accept;

  assign accept = start && !busy;

  seq_mul_sign #(.W(W)) u_sign (
    .a(op_a), .b(op_b), .signed_op(func == FN_SHI),
    .mag_a(mag_a), .mag_b(mag_b), .negate(neg_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      fn_q  <= FN_LOW;
    end else if (accept) begin
      neg_q <= neg_now;
      fn_q  <= mul_fn_e'(func);
    end
  end

  seq_mul_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .mcand_in(mag_a), .mplier_in(mag_b),
    .running(busy), .finish(done), .prod(prod)
  );

  seq_mul_select #(.W(W)) u_sel (
    .prod(prod), .negate(neg_q), .fn(fn_q), .result(result)
  );

  // R2: an idle start begins a run
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R10: the result holds while idle with no new request
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  // R5: the captured function code cannot change mid-run
  p_fn_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fn_q));
  // R3: done only follows a busy cycle
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/seq_mul_test.sv
module seq_mul_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   func = 2'b00;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  seq_mul uut (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] f);
    logic signed [127:0] sp;
    logic [127:0] up;
    sp = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    up = {64'b0, a} * {64'b0, b};
    case (f)
      2'b01:   return sp[127:64];
      2'b10:   return up[127:64];
      default: return up[63:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] f);
    case (f)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  // One run: accept on edge 0, optional stray start at edge 'stray_at'
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input logic [1:0] f, input int stray_at, input string extra);
    logic [63:0] exp;
    exp = model(a, b, f);
    @(negedge clk);
    op_a = a; op_b = b; func = f; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R2 busy", 64'(busy), 64'd1);
    for (int e = 1; e <= 63; e++) begin
      if (e == stray_at) begin
        @(negedge clk);
        op_a = ~a; op_b = b ^ 64'h5a5a; func = ~f; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
      end else begin
        @(posedge clk); #1;
      end
    end
    check("R3 busy@63", 64'({busy, done}), 64'b10);
    @(posedge clk); #1;
    check(stray_at > 0 ? "R5 done timing" : "R3 done@64", 64'({busy, done}), 64'b01);
    check(stray_at > 0 ? "R5 result" : (extra != "" ? extra : tag_of(f)), result, exp);
    @(posedge clk); #1;
    check("R4 done pulse", 64'(done), 64'd0);
    check("R10 hold", result, exp);
  endtask

  initial begin
    int unsigned seed;
    logic [63:0] corner [6];
    seed = 32'd20240611;
    void'($urandom(seed));
    #1;
    check("R1 reset", 64'({busy, done}), 64'b00);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 64'({busy, done}), 64'b00);

    run_op(64'd3, 64'd5, 2'b00, 0, "");
    run_op(64'hffff_ffff_ffff_ffff, 64'd2, 2'b01, 0, "");
    run_op(64'hffff_ffff_ffff_ffff, 64'd2, 2'b10, 0, "");
    run_op(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321, 2'b11, 0, "");
    run_op(64'd7, 64'd9, 2'b00, 10, "");
    run_op(64'h8000_0000_0000_0000, 64'h1111, 2'b01, 40, "");

    corner[0] = 64'h8000_0000_0000_0000;
    corner[1] = 64'hffff_ffff_ffff_ffff;
    corner[2] = 64'd0;
    corner[3] = 64'd1;
    corner[4] = 64'h7fff_ffff_ffff_ffff;
    corner[5] = 64'h8000_0000_0000_0001;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j += 2)
        for (int f = 0; f < 4; f++)
          run_op(corner[i], corner[j], 2'(f), 0, "R11 corner");

    for (int k = 0; k < 200; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      run_op(ra, rb, 2'($urandom % 4), (k % 9 == 0) ? int'($urandom % 60) + 2 : 0, "");
    end

    // R5: start held high through a whole run is still a single request
    @(negedge clk); start = 1'b1; op_a = 64'd11; op_b = 64'd13; func = 2'b00;
    @(posedge clk); #1;
    op_a = 64'd99;
    repeat (64) @(posedge clk);
    #1;
    check("R5 held start", result, 64'd143);
    start = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule